// File: doc/BRIEF.md
# Pin-Multiplexing General-Purpose I/O Controller

This block sits between a set of chip pads and an APB host. Each pad can be driven by the block's own data and direction registers, or handed to one of two on-chip peripherals (source A or source B). For every pad the block drives an output value, an output enable, an input enable, a weak pull-up, a weak pull-down and a high-drive select. The channel count is a parameter and may be 16 or 32. The APB data bus has the same width as the channel count.

Pad inputs pass through a two-flop synchroniser. The synchronised value feeds a read-only input register and the interrupt logic. Each pin has its own enable and active level for a level-sensitive interrupt, and the enabled pins that are at their active level are ORed onto one interrupt line. The peripherals receive the pad inputs unsynchronised. A test-mode input hands every pad control output to external test logic, whatever the registers and the peripherals are doing.

The APB side runs a three-state phase tracker. ST_IDLE moves to ST_SETUP when PSEL is high with PENABLE low. ST_SETUP moves to ST_ACCESS when PENABLE rises with PSEL still high, stays in ST_SETUP while PSEL is high and PENABLE is low, and otherwise falls back to ST_IDLE. ST_ACCESS moves to ST_SETUP on a new setup phase and otherwise returns to ST_IDLE. A write commits only on the ST_SETUP to ST_ACCESS transition.

Top module: `gpio_pinmux_ctrl`

## Requirements
- R1: After the asynchronous reset every register holds its reset parameter value, which defaults to zero. With the defaults, all pad control outputs and the interrupt line are low.
- R2: The read/write registers read back the last value written. Word offsets (byte address): 0x00 output data, 0x08 output enable, 0x0C input enable, 0x10 mode (1 = peripheral), 0x14 source select (0 = A, 1 = B), 0x18 pull-up, 0x1C pull-down, 0x20 high drive, 0x24 interrupt enable, 0x28 interrupt polarity.
- R3: Offset 0x04 returns the pad inputs after two clock edges of synchronisation. Writes to 0x04 and 0x2C have no effect.
- R4: A pad with mode bit 0 takes its output value, output enable and input enable from the output data, output enable and input enable registers.
- R5: A pad with mode bit 1 takes its output value, output enable and input enable from source A when its source bit is 0, and from source B when its source bit is 1.
- R6: The pull-up and high-drive outputs follow their registers in every mode. The pull-down output follows its register except where the pull-up bit is also set, in which case the pull-down output is 0.
- R7: The status bit at 0x2C for a pin is 1 when its interrupt enable is 1 and its synchronised input equals its polarity bit (1 = active high, 0 = active low). The interrupt output is the OR of the status bits.
- R8: While the test-mode input is high, all six pad control outputs equal the matching test inputs bit for bit, with no pull conflict masking. Register contents stay unchanged.
- R9: Unmapped word offsets, and addresses with bit 1 or bit 0 set, read as zero and ignore writes. PREADY is always high and PSLVERR is always low.
- R10: The peripheral input bus equals the pad inputs in the same cycle, without synchronisation.
- R11: A write commits only when PSEL and PENABLE are both high after a setup cycle (PSEL high, PENABLE low). An access phase with no setup phase before it, or PENABLE with PSEL low, writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 10 | APB byte address |
| pwdata | input | NCH | APB write data |
| prdata | output | NCH | APB read data |
| pready | output | 1 | Transfer ready, always high |
| pslverr | output | 1 | Transfer error, always low |
| pad_in | input | NCH | Values from the pads |
| pad_out | output | NCH | Values driven to the pads |
| pad_oe | output | NCH | Pad output enables |
| pad_ie | output | NCH | Pad input enables |
| pad_pu | output | NCH | Weak pull-up selects |
| pad_pd | output | NCH | Weak pull-down selects |
| pad_hd | output | NCH | High-drive selects |
| alt_in | output | NCH | Raw pad inputs for the peripherals |
| alt_a_out | input | NCH | Source A output values |
| alt_a_oe | input | NCH | Source A output enables |
| alt_a_ie | input | NCH | Source A input enables |
| alt_b_out | input | NCH | Source B output values |
| alt_b_oe | input | NCH | Source B output enables |
| alt_b_ie | input | NCH | Source B input enables |
| test_mode | input | 1 | Hands pad control to test logic |
| test_out | input | NCH | Test output values |
| test_oe | input | NCH | Test output enables |
| test_ie | input | NCH | Test input enables |
| test_pu | input | NCH | Test pull-up selects |
| test_pd | input | NCH | Test pull-down selects |
| test_hd | input | NCH | Test high-drive selects |
| irq | output | 1 | Combined level interrupt |

## Verification
The assertions assume that the host keeps to the APB phase order. A change in the output data register may follow only a cycle in which the tracker was in ST_SETUP with a write strobe, and ST_ACCESS may follow only ST_SETUP. The stimulus uses proper two-phase transfers, except for two deliberately malformed sequences that test R11 and that no assertion depends on. Pad, peripheral and test inputs change only at the falling edge, so the synchroniser sees stable values. The pull-conflict assertion is checked only outside test mode, where the stimulus sets both pull bits on some pins on purpose.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } apb_state_e;

    localparam int ADDR_W = 10;
    localparam int IDX_W  = ADDR_W - 2;

    localparam logic [IDX_W-1:0] IDX_DOUT  = 8'd0;
    localparam logic [IDX_W-1:0] IDX_DIN   = 8'd1;
    localparam logic [IDX_W-1:0] IDX_OE    = 8'd2;
    localparam logic [IDX_W-1:0] IDX_IE    = 8'd3;
    localparam logic [IDX_W-1:0] IDX_MODE  = 8'd4;
    localparam logic [IDX_W-1:0] IDX_SRC   = 8'd5;
    localparam logic [IDX_W-1:0] IDX_PU    = 8'd6;
    localparam logic [IDX_W-1:0] IDX_PD    = 8'd7;
    localparam logic [IDX_W-1:0] IDX_HD    = 8'd8;
    localparam logic [IDX_W-1:0] IDX_IEN   = 8'd9;
    localparam logic [IDX_W-1:0] IDX_IPOL  = 8'd10;
    localparam logic [IDX_W-1:0] IDX_ISTAT = 8'd11;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/gpio_apb_regs.sv
module gpio_apb_regs
    import gpio_mux_pkg::*;
#(
    parameter int             NCH      = 32,
    parameter logic [NCH-1:0] RST_DOUT = '0,
    parameter logic [NCH-1:0] RST_OE   = '0,
    parameter logic [NCH-1:0] RST_IE   = '0,
    parameter logic [NCH-1:0] RST_MODE = '0,
    parameter logic [NCH-1:0] RST_SRC  = '0,
    parameter logic [NCH-1:0] RST_PU   = '0,
    parameter logic [NCH-1:0] RST_PD   = '0,
    parameter logic [NCH-1:0] RST_HD   = '0,
    parameter logic [NCH-1:0] RST_IEN  = '0,
    parameter logic [NCH-1:0] RST_IPOL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [NCH-1:0]    pwdata,
    output logic [NCH-1:0]    prdata,
    input  logic [NCH-1:0]    din,
    input  logic [NCH-1:0]    istat,
    output logic [NCH-1:0]    dout_q,
    output logic [NCH-1:0]    oe_q,
    output logic [NCH-1:0]    ie_q,
    output logic [NCH-1:0]    mode_q,
    output logic [NCH-1:0]    src_q,
    output logic [NCH-1:0]    pu_q,
    output logic [NCH-1:0]    pd_q,
    output logic [NCH-1:0]    hd_q,
    output logic [NCH-1:0]    ien_q,
    output logic [NCH-1:0]    ipol_q
);
    apb_state_e       state_q, state_d;
    logic             wr_en;
    logic             aligned;
    logic [IDX_W-1:0] idx;

    assign aligned = (paddr[1:0] == 2'b00);
    assign idx     = paddr[ADDR_W-1:2];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            ST_SETUP:  state_d = !psel ? ST_IDLE : (penable ? ST_ACCESS : ST_SETUP);
            ST_ACCESS: state_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_en = 1'b0;
        unique case (state_q)
            ST_SETUP: wr_en = psel && penable && pwrite;
            default:  wr_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= RST_DOUT;
            oe_q   <= RST_OE;
            ie_q   <= RST_IE;
            mode_q <= RST_MODE;
            src_q  <= RST_SRC;
            pu_q   <= RST_PU;
            pd_q   <= RST_PD;
            hd_q   <= RST_HD;
            ien_q  <= RST_IEN;
            ipol_q <= RST_IPOL;
        end else if (wr_en && aligned) begin
            case (idx)
                IDX_DOUT: dout_q <= pwdata;
                IDX_OE:   oe_q   <= pwdata;
                IDX_IE:   ie_q   <= pwdata;
                IDX_MODE: mode_q <= pwdata;
                IDX_SRC:  src_q  <= pwdata;
                IDX_PU:   pu_q   <= pwdata;
                IDX_PD:   pd_q   <= pwdata;
                IDX_HD:   hd_q   <= pwdata;
                IDX_IEN:  ien_q  <= pwdata;
                IDX_IPOL: ipol_q <= pwdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        if (aligned) begin
            case (idx)
                IDX_DOUT:  prdata = dout_q;
                IDX_DIN:   prdata = din;
                IDX_OE:    prdata = oe_q;
                IDX_IE:    prdata = ie_q;
                IDX_MODE:  prdata = mode_q;
                IDX_SRC:   prdata = src_q;
                IDX_PU:    prdata = pu_q;
                IDX_PD:    prdata = pd_q;
                IDX_HD:    prdata = hd_q;
                IDX_IEN:   prdata = ien_q;
                IDX_IPOL:  prdata = ipol_q;
                IDX_ISTAT: prdata = istat;
                default:   prdata = '0;
            endcase
        end
    end

    // R11
    access_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCESS) |-> $past(state_q == ST_SETUP));

    // R11
    dout_write_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_q) |-> $past(wr_en));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int NCH = 32
) (
    input  logic           test_mode,
    input  logic [NCH-1:0] reg_out,
    input  logic [NCH-1:0] reg_oe,
    input  logic [NCH-1:0] reg_ie,
    input  logic [NCH-1:0] reg_mode,
    input  logic [NCH-1:0] reg_src,
    input  logic [NCH-1:0] reg_pu,
    input  logic [NCH-1:0] reg_pd,
    input  logic [NCH-1:0] reg_hd,
    input  logic [NCH-1:0] a_out,
    input  logic [NCH-1:0] a_oe,
    input  logic [NCH-1:0] a_ie,
    input  logic [NCH-1:0] b_out,
    input  logic [NCH-1:0] b_oe,
    input  logic [NCH-1:0] b_ie,
    input  logic [NCH-1:0] t_out,
    input  logic [NCH-1:0] t_oe,
    input  logic [NCH-1:0] t_ie,
    input  logic [NCH-1:0] t_pu,
    input  logic [NCH-1:0] t_pd,
    input  logic [NCH-1:0] t_hd,
    output logic [NCH-1:0] pad_out,
    output logic [NCH-1:0] pad_oe,
    output logic [NCH-1:0] pad_ie,
    output logic [NCH-1:0] pad_pu,
    output logic [NCH-1:0] pad_pd,
    output logic [NCH-1:0] pad_hd
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_comb begin
            if (test_mode) begin
                pad_out[i] = t_out[i];
                pad_oe[i]  = t_oe[i];
                pad_ie[i]  = t_ie[i];
                pad_pu[i]  = t_pu[i];
                pad_pd[i]  = t_pd[i];
                pad_hd[i]  = t_hd[i];
            end else begin
                if (!reg_mode[i]) begin
                    pad_out[i] = reg_out[i];
                    pad_oe[i]  = reg_oe[i];
                    pad_ie[i]  = reg_ie[i];
                end else if (!reg_src[i]) begin
                    pad_out[i] = a_out[i];
                    pad_oe[i]  = a_oe[i];
                    pad_ie[i]  = a_ie[i];
                end else begin
                    pad_out[i] = b_out[i];
                    pad_oe[i]  = b_oe[i];
                    pad_ie[i]  = b_ie[i];
                end
                pad_pu[i] = reg_pu[i];
                pad_pd[i] = reg_pd[i] & ~reg_pu[i];
                pad_hd[i] = reg_hd[i];
            end
        end
    end

    // R6
    always_comb begin
        if (!test_mode) begin
            pull_conflict_chk: assert ((pad_pu & pad_pd) == '0);
        end
    end
endmodule

// File: rtl/gpio_pinmux_ctrl.sv
module gpio_pinmux_ctrl
    import gpio_mux_pkg::*;
#(
    parameter int             NCH      = 32,
    parameter logic [NCH-1:0] RST_DOUT = '0,
    parameter logic [NCH-1:0] RST_OE   = '0,
    parameter logic [NCH-1:0] RST_IE   = '0,
    parameter logic [NCH-1:0] RST_MODE = '0,
    parameter logic [NCH-1:0] RST_SRC  = '0,
    parameter logic [NCH-1:0] RST_PU   = '0,
    parameter logic [NCH-1:0] RST_PD   = '0,
    parameter logic [NCH-1:0] RST_HD   = '0,
    parameter logic [NCH-1:0] RST_IEN  = '0,
    parameter logic [NCH-1:0] RST_IPOL = '0
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [NCH-1:0]    pwdata,
    output logic [NCH-1:0]    prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [NCH-1:0]    pad_in,
    output logic [NCH-1:0]    pad_out,
    output logic [NCH-1:0]    pad_oe,
    output logic [NCH-1:0]    pad_ie,
    output logic [NCH-1:0]    pad_pu,
    output logic [NCH-1:0]    pad_pd,
    output logic [NCH-1:0]    pad_hd,
    output logic [NCH-1:0]    alt_in,
    input  logic [NCH-1:0]    alt_a_out,
    input  logic [NCH-1:0]    alt_a_oe,
    input  logic [NCH-1:0]    alt_a_ie,
    input  logic [NCH-1:0]    alt_b_out,
    input  logic [NCH-1:0]    alt_b_oe,
    input  logic [NCH-1:0]    alt_b_ie,
    input  logic              test_mode,
    input  logic [NCH-1:0]    test_out,
    input  logic [NCH-1:0]    test_oe,
    input  logic [NCH-1:0]    test_ie,
    input  logic [NCH-1:0]    test_pu,
    input  logic [NCH-1:0]    test_pd,
    input  logic [NCH-1:0]    test_hd,
    output logic              irq
);
    if (!(NCH == 16 || NCH == 32)) begin : g_bad_nch
        $error("channel count must be 16 or 32");
    end

    logic [NCH-1:0] din_sync;
    logic [NCH-1:0] istat;
    logic [NCH-1:0] dout_q, oe_q, ie_q, mode_q, src_q;
    logic [NCH-1:0] pu_q, pd_q, hd_q, ien_q, ipol_q;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign alt_in  = pad_in;

    gpio_in_sync #(.W(NCH)) u_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .d     (pad_in),
        .q     (din_sync)
    );

    assign istat = ien_q & ~(din_sync ^ ipol_q);
    assign irq   = |istat;

    gpio_apb_regs #(
        .NCH(NCH), .RST_DOUT(RST_DOUT), .RST_OE(RST_OE), .RST_IE(RST_IE),
        .RST_MODE(RST_MODE), .RST_SRC(RST_SRC), .RST_PU(RST_PU),
        .RST_PD(RST_PD), .RST_HD(RST_HD), .RST_IEN(RST_IEN), .RST_IPOL(RST_IPOL)
    ) u_regs (
        .clk     (pclk),
        .rst_n   (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .din     (din_sync),
        .istat   (istat),
        .dout_q  (dout_q),
        .oe_q    (oe_q),
        .ie_q    (ie_q),
        .mode_q  (mode_q),
        .src_q   (src_q),
        .pu_q    (pu_q),
        .pd_q    (pd_q),
        .hd_q    (hd_q),
        .ien_q   (ien_q),
        .ipol_q  (ipol_q)
    );

    gpio_pad_mux #(.NCH(NCH)) u_mux (
        .test_mode (test_mode),
        .reg_out   (dout_q),
        .reg_oe    (oe_q),
        .reg_ie    (ie_q),
        .reg_mode  (mode_q),
        .reg_src   (src_q),
        .reg_pu    (pu_q),
        .reg_pd    (pd_q),
        .reg_hd    (hd_q),
        .a_out     (alt_a_out),
        .a_oe      (alt_a_oe),
        .a_ie      (alt_a_ie),
        .b_out     (alt_b_out),
        .b_oe      (alt_b_oe),
        .b_ie      (alt_b_ie),
        .t_out     (test_out),
        .t_oe      (test_oe),
        .t_ie      (test_ie),
        .t_pu      (test_pu),
        .t_pd      (test_pd),
        .t_hd      (test_hd),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_ie    (pad_ie),
        .pad_pu    (pad_pu),
        .pad_pd    (pad_pd),
        .pad_hd    (pad_hd)
    );

    // R7
    irq_needs_enable_chk: assert property (@(posedge pclk) disable iff (!presetn)
        irq |-> (ien_q != '0));

    // R7
    status_within_enable_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (istat & ~ien_q) == '0);
endmodule

// File: tb/sim_gpio_pinmux_ctrl.sv
module sim_gpio_pinmux_ctrl;
    localparam int CLK_P = 10;
    localparam int N = 32;

    logic          pclk = 1'b0;
    logic          presetn = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [9:0]    paddr = '0;
    logic [N-1:0]  pwdata = '0;
    logic [N-1:0]  prdata;
    logic          pready, pslverr;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe, pad_ie, pad_pu, pad_pd, pad_hd, alt_in;
    logic [N-1:0]  alt_a_out = '0, alt_a_oe = '0, alt_a_ie = '0;
    logic [N-1:0]  alt_b_out = '0, alt_b_oe = '0, alt_b_ie = '0;
    logic          test_mode = 1'b0;
    logic [N-1:0]  test_out = '0, test_oe = '0, test_ie = '0;
    logic [N-1:0]  test_pu = '0, test_pd = '0, test_hd = '0;
    logic          irq;

    always #(CLK_P/2) pclk = ~pclk;

    gpio_pinmux_ctrl #(.NCH(N)) u0 (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_hd(pad_hd), .alt_in(alt_in),
        .alt_a_out(alt_a_out), .alt_a_oe(alt_a_oe), .alt_a_ie(alt_a_ie),
        .alt_b_out(alt_b_out), .alt_b_oe(alt_b_oe), .alt_b_ie(alt_b_ie),
        .test_mode(test_mode), .test_out(test_out), .test_oe(test_oe),
        .test_ie(test_ie), .test_pu(test_pu), .test_pd(test_pd),
        .test_hd(test_hd), .irq(irq)
    );

    typedef struct {
        string       req;
        logic [31:0] exp;
        logic [31:0] act;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // driver side: push one expected/actual pair into the scoreboard
    task automatic expect_eq(input string req, input logic [31:0] exp, input logic [31:0] act);
        item_t it;
        it.req = req;
        it.exp = exp;
        it.act = act;
        sb_q.push_back(it);
    endtask

    // monitor: drains the scoreboard and compares
    initial begin
        forever begin
            @(posedge pclk);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (it.act !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", it.req, it.act, it.exp);
                end
            end
        end
    end

    task automatic apb_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [9:0] a, output logic [31:0] d,
                            output logic err, output logic rdy);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        d = prdata; err = pslverr; rdy = pready;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic e, r;
        apb_read(a, d, e, r);
        expect_eq(req, exp, d);
    endtask

    function automatic logic [31:0] mux3(input logic [31:0] md, input logic [31:0] sr,
                                         input logic [31:0] g, input logic [31:0] a,
                                         input logic [31:0] b);
        return (~md & g) | (md & ~sr & a) | (md & sr & b);
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        er, ry;
        logic [9:0]  waddr [10];
        logic [31:0] wdat  [10];
        logic [31:0] mode_v, src_v;

        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);

        // R1 reset state
        expect_eq("R1 pad_out", 32'h0, pad_out);
        expect_eq("R1 pad_oe", 32'h0, pad_oe);
        expect_eq("R1 pad_ie", 32'h0, pad_ie);
        expect_eq("R1 pulls/drive", 32'h0, pad_pu | pad_pd | pad_hd);
        expect_eq("R1 irq", 32'h0, {31'h0, irq});
        read_check("R1 mode reg", 10'h010, 32'h0);

        // R9 unmapped, misaligned, handshake outputs
        apb_read(10'h030, rd, er, ry);
        expect_eq("R9 unmapped 0x30", 32'h0, rd);
        expect_eq("R9 pslverr", 32'h0, {31'h0, er});
        expect_eq("R9 pready", 32'h1, {31'h0, ry});
        read_check("R9 unmapped 0x3FC", 10'h3FC, 32'h0);
        apb_write(10'h002, 32'hFFFF_FFFF);
        read_check("R9 misaligned write ignored", 10'h000, 32'h0);
        read_check("R9 misaligned read zero", 10'h001, 32'h0);

        // R2 readback of read/write registers
        waddr[0] = 10'h000; wdat[0] = 32'hA5A5_5A5A;
        waddr[1] = 10'h008; wdat[1] = 32'hFF00_FF00;
        waddr[2] = 10'h00C; wdat[2] = 32'h0F0F_0F0F;
        waddr[3] = 10'h020; wdat[3] = 32'h1234_5678;
        waddr[4] = 10'h018; wdat[4] = 32'h0000_FFFF;
        waddr[5] = 10'h01C; wdat[5] = 32'h00FF_00FF;
        waddr[6] = 10'h024; wdat[6] = 32'h0000_00F0;
        waddr[7] = 10'h028; wdat[7] = 32'h0000_00A0;
        waddr[8] = 10'h010; wdat[8] = 32'h0000_0000;
        waddr[9] = 10'h014; wdat[9] = 32'h0000_0000;
        for (int i = 0; i < 10; i++) apb_write(waddr[i], wdat[i]);
        for (int i = 0; i < 10; i++) read_check("R2 readback", waddr[i], wdat[i]);

        // R4 register-driven pads
        @(negedge pclk);
        expect_eq("R4 pad_out", 32'hA5A5_5A5A, pad_out);
        expect_eq("R4 pad_oe", 32'hFF00_FF00, pad_oe);
        expect_eq("R4 pad_ie", 32'h0F0F_0F0F, pad_ie);

        // R6 pulls and drive, pull-down masked by pull-up
        expect_eq("R6 pad_pu", 32'h0000_FFFF, pad_pu);
        expect_eq("R6 pad_pd", 32'h00FF_0000, pad_pd);
        expect_eq("R6 pad_hd", 32'h1234_5678, pad_hd);

        // R5 peripheral selection
        alt_a_out = 32'h3C3C_3C3C; alt_a_oe = 32'hFFFF_FFFF; alt_a_ie = 32'h0000_0000;
        alt_b_out = 32'hC3C3_C3C3; alt_b_oe = 32'h0000_0000; alt_b_ie = 32'hFFFF_FFFF;
        mode_v = 32'hFFFF_0000; src_v = 32'hFF00_0000;
        apb_write(10'h010, mode_v);
        apb_write(10'h014, src_v);
        @(negedge pclk);
        expect_eq("R5 pad_out mixed", mux3(mode_v, src_v, 32'hA5A5_5A5A, alt_a_out, alt_b_out), pad_out);
        expect_eq("R5 pad_oe mixed", mux3(mode_v, src_v, 32'hFF00_FF00, alt_a_oe, alt_b_oe), pad_oe);
        expect_eq("R5 pad_ie mixed", mux3(mode_v, src_v, 32'h0F0F_0F0F, alt_a_ie, alt_b_ie), pad_ie);
        expect_eq("R6 pad_pd in peripheral mode", 32'h00FF_0000, pad_pd);
        apb_write(10'h010, 32'hFFFF_FFFF);
        apb_write(10'h014, 32'hFFFF_FFFF);
        @(negedge pclk);
        expect_eq("R5 all source B", alt_b_out, pad_out);
        apb_write(10'h014, 32'h0000_0000);
        @(negedge pclk);
        expect_eq("R5 all source A", alt_a_out, pad_out);

        // R8 test override
        test_out = 32'h0BAD_F00D; test_oe = 32'h5555_5555; test_ie = 32'hAAAA_AAAA;
        test_pu = 32'hFFFF_FFFF; test_pd = 32'hFFFF_FFFF; test_hd = 32'h0F0F_0000;
        test_mode = 1'b1;
        @(negedge pclk);
        expect_eq("R8 pad_out", test_out, pad_out);
        expect_eq("R8 pad_oe", test_oe, pad_oe);
        expect_eq("R8 pad_ie", test_ie, pad_ie);
        expect_eq("R8 pad_pu", test_pu, pad_pu);
        expect_eq("R8 pad_pd unmasked", test_pd, pad_pd);
        expect_eq("R8 pad_hd", test_hd, pad_hd);
        apb_write(10'h010, 32'h0000_0000);
        @(negedge pclk);
        expect_eq("R8 register change ignored", test_out, pad_out);
        test_mode = 1'b0;
        read_check("R8 registers kept", 10'h020, 32'h1234_5678);
        @(negedge pclk);
        expect_eq("R4 pads back to registers", 32'hA5A5_5A5A, pad_out);

        // R10 raw input to peripherals, R3 synchronised input register
        @(negedge pclk);
        pad_in = 32'hDEAD_BEEF;
        #1;
        expect_eq("R10 alt_in same cycle", 32'hDEAD_BEEF, alt_in);
        read_check("R3 din after sync", 10'h004, 32'hDEAD_BEEF);
        apb_write(10'h004, 32'h0000_0000);
        read_check("R3 din write ignored", 10'h004, 32'hDEAD_BEEF);

        // R7 status and combined line: en F0, pol A0, input EF -> B0
        read_check("R7 status", 10'h02C, 32'h0000_00F0 & ~(32'hDEAD_BEEF ^ 32'h0000_00A0));
        expect_eq("R7 irq high", 32'h1, {31'h0, irq});
        apb_write(10'h02C, 32'h0000_0000);
        read_check("R3 status write ignored", 10'h02C, 32'h0000_00B0);
        apb_write(10'h024, 32'h0000_0000);
        expect_eq("R7 irq low when disabled", 32'h0, {31'h0, irq});

        // R3/R7 two-edge latency, active-high then active-low
        apb_write(10'h028, 32'h0000_0001);
        apb_write(10'h024, 32'h0000_0001);
        expect_eq("R7 active-high asserted", 32'h1, {31'h0, irq});
        pad_in = 32'hDEAD_BEEE;
        @(negedge pclk);
        expect_eq("R3 one edge: old level", 32'h1, {31'h0, irq});
        @(negedge pclk);
        expect_eq("R3 two edges: new level", 32'h0, {31'h0, irq});
        apb_write(10'h028, 32'h0000_0000);
        expect_eq("R7 active-low asserted", 32'h1, {31'h0, irq});

        // R11 malformed transfers write nothing
        apb_write(10'h000, 32'h0000_1234);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b1; pwrite = 1'b1; paddr = 10'h000; pwdata = 32'hFFFF_FFFF;
        @(negedge pclk);
        psel = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        read_check("R11 no write without setup", 10'h000, 32'h0000_1234);
        expect_eq("R11 pad_out unchanged", 32'h0000_1234, pad_out);

        wait (sb_q.size() == 0);
        @(posedge pclk);
        #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule